// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a three-wire link to a 16-bit successive-approximation converter. The converter starts a conversion when its active-low select falls. It stays silent for a fixed number of clock pulses, then drives a zero marker bit. After the marker it shifts out its result, most significant bit first, one bit per falling clock edge. The host controls the select line and the serial clock, and it reads the serial data line.

A one-cycle `start_i` request in the idle state begins a frame. The reader lowers select and waits one half period. It then sends exactly 24 clock pulses, because the converter needs at least 22 to finish a conversion. The reader samples the data line on each rising clock edge. It drops the samples from the dead pulses, checks the marker and shifts in the 16 result bits. At the last falling edge it raises select and presents the word with a one-cycle `valid_o` strobe. The `div_i` input sets the clock rate and is captured when the frame starts. After each frame the select line stays high for a minimum idle time counted in system clocks. This keeps the converter within its throughput limit.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after a synchronous reset with no start request: `cs_n_o`=1, `sclk_o`=0, `busy_o`=0, `valid_o`=0, `err_o`=0 and `result_o`=0.
- R2: A `start_i` high in a cycle where `busy_o` is 0 drives `cs_n_o` low and `busy_o` high after the next clock edge. A `start_i` high while `busy_o` is 1 starts no frame.
- R3: Each frame has exactly FRAME_CLKS (default 24) rising edges of `sclk_o` while `cs_n_o` is low.
- R4: Each high phase and each low phase of `sclk_o` lasts `div_i`+1 system clocks. The first rising edge comes 2·(`div_i`+1) clocks after `cs_n_o` falls. `cs_n_o` stays low for (2·FRAME_CLKS+1)·(`div_i`+1) clocks in total.
- R5: The data line is sampled at rising edges of `sclk_o`. The samples at rising edges 7 through 22 of a frame form `result_o` bits 15 down to 0, as an unsigned binary word.
- R6: The sample at rising edge 6 is the marker, which follows the 5th falling edge. `err_o` is loaded with 1 if the marker is 1 and with 0 if it is 0, at the same time as `result_o`.
- R7: `valid_o` is high for exactly one cycle per frame, and that is the first cycle in which `cs_n_o` is high again. `result_o` and `err_o` keep their values until the next `valid_o`.
- R8: After a frame `busy_o` stays high for exactly IDLE_CLKS (default 16) cycles after `cs_n_o` rises. `cs_n_o` never falls after less than IDLE_CLKS cycles high.
- R9: Data-line values at rising edges 1 to 5 and after rising edge 22 have no effect on `result_o` or `err_o`.
- R10: `sclk_o` is low in every cycle in which `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion frame (accepted when idle) |
| div_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial data clock to the converter |
| result_o | output | DATA_W | Last conversion result |
| valid_o | output | 1 | One-cycle strobe when a new result is presented |
| busy_o | output | 1 | Frame or idle gap in progress |
| err_o | output | 1 | Marker bit of the last frame was not zero |

## Verification
The checker watches the clock and select relationships on every cycle. It checks that the clock is low while select is high and that each clock high phase matches the divider. It also checks the pulse count per frame, the one-cycle strobe at the select rise, busy covering the selected window and the minimum high time of select. Only the bench scenarios can show that the right bits reach the result word. For this the bench drives a converter model with known words, a corrupted marker and junk in the dead and trailing pulses. The bench scenarios also show that a start request during a frame is dropped.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_t;

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  // one tick every div_i+1 cycles while running; restarts from zero when run drops
  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DATA_W   = 16,
  parameter int MARK_IDX = 6,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] word_o,
  output logic              mark_bad_o
);

  localparam logic [IDX_W-1:0] MARK_L  = IDX_W'(MARK_IDX);
  localparam logic [IDX_W-1:0] FIRST_L = IDX_W'(MARK_IDX + 1);
  localparam logic [IDX_W-1:0] LAST_L  = IDX_W'(MARK_IDX + DATA_W);

  logic in_window;
  assign in_window = (idx_i >= FIRST_L) && (idx_i <= LAST_L);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      word_o     <= '0;
      mark_bad_o <= 1'b0;
    end else if (sample_i) begin
      if (idx_i == MARK_L) begin
        mark_bad_o <= sdi_i;
      end
      if (in_window) begin
        word_o <= {word_o[DATA_W-2:0], sdi_i};
      end
    end
  end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FRAME_CLKS = 24,
  parameter int IDLE_CLKS  = 16,
  localparam int CNT_W     = $clog2(FRAME_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [DIV_W-1:0] div_o,
  output logic             clear_o,
  output logic             sample_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             end_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             busy_o
);

  localparam int GAP_W = (IDLE_CLKS > 1) ? $clog2(IDLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_CLKS - 1);
  localparam logic [GAP_W-1:0] GAP_END   = GAP_W'(IDLE_CLKS - 1);

  rd_state_t        state_q;
  logic             cs_n_q, sclk_q;
  logic [CNT_W-1:0] rise_q, fall_q;
  logic [GAP_W-1:0] gap_q;
  logic [DIV_W-1:0] div_q;

  assign run_o    = (state_q == ST_SETUP) || (state_q == ST_RUN);
  assign div_o    = div_q;
  assign clear_o  = (state_q == ST_IDLE) && start_i;
  assign sample_o = (state_q == ST_RUN) && tick_i && !sclk_q;
  assign idx_o    = rise_q + 1'b1;
  assign end_o    = (state_q == ST_RUN) && tick_i && sclk_q && (fall_q == LAST_FALL);
  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      rise_q  <= '0;
      fall_q  <= '0;
      gap_q   <= '0;
      div_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SETUP;
            cs_n_q  <= 1'b0;
            div_q   <= div_i;
            rise_q  <= '0;
            fall_q  <= '0;
          end
        end
        ST_SETUP: begin
          if (tick_i) begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rise_q <= rise_q + 1'b1;
            end else begin
              sclk_q <= 1'b0;
              fall_q <= fall_q + 1'b1;
              if (fall_q == LAST_FALL) begin
                state_q <= ST_GAP;
                cs_n_q  <= 1'b1;
                gap_q   <= '0;
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_END) begin
            state_q <= ST_IDLE;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DATA_W     = 16,
  parameter int LEAD_FALLS = 5,
  parameter int FRAME_CLKS = 24,
  parameter int DIV_W      = 8,
  parameter int IDLE_CLKS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              sdi_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              err_o
);

  localparam int MARK_IDX = LEAD_FALLS + 1;
  localparam int IDX_W    = $clog2(FRAME_CLKS + 1);

  logic             tick, run, clear, sample, frame_end, mark_bad;
  logic [DIV_W-1:0] div_lat;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] result_q;
  logic             valid_q, err_q;

  adc_rd_tick #(.DIV_W(DIV_W)) tick_i (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .div_i  (div_lat),
    .tick_o (tick)
  );

  adc_rd_ctrl #(
    .DIV_W      (DIV_W),
    .FRAME_CLKS (FRAME_CLKS),
    .IDLE_CLKS  (IDLE_CLKS)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .div_i    (div_i),
    .tick_i   (tick),
    .run_o    (run),
    .div_o    (div_lat),
    .clear_o  (clear),
    .sample_o (sample),
    .idx_o    (idx),
    .end_o    (frame_end),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .busy_o   (busy_o)
  );

  adc_rd_capture #(
    .DATA_W   (DATA_W),
    .MARK_IDX (MARK_IDX),
    .IDX_W    (IDX_W)
  ) cap_i (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (clear),
    .sample_i   (sample),
    .idx_i      (idx),
    .sdi_i      (sdi_i),
    .word_o     (word),
    .mark_bad_o (mark_bad)
  );

  // result registered on the same edge that deselects the converter
  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      err_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= frame_end;
      if (frame_end) begin
        result_q <= word;
        err_q    <= mark_bad;
      end
    end
  end

  assign result_o = result_q;
  assign err_o    = err_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int DIV_W      = 8,
  parameter int FRAME_CLKS = 24,
  parameter int IDLE_CLKS  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] div_i,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             valid_o,
  input logic             busy_o
);

  localparam int RC_W = $clog2(FRAME_CLKS + 1) + 1;
  localparam int HI_W = $clog2(IDLE_CLKS + 1) + 1;

  logic            cs_q, sk_q;
  logic [DIV_W:0]  ev_cnt;
  logic [RC_W-1:0] rise_cnt;
  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      sk_q     <= 1'b0;
      ev_cnt   <= '0;
      rise_cnt <= '0;
      hi_cnt   <= HI_W'(IDLE_CLKS);
    end else begin
      cs_q <= cs_n_o;
      sk_q <= sclk_o;
      if (sclk_o != sk_q) begin
        ev_cnt <= 1;
      end else if (ev_cnt != '1) begin
        ev_cnt <= ev_cnt + 1'b1;
      end
      if (cs_n_o && cs_q) begin
        rise_cnt <= '0;
      end else if (sclk_o && !sk_q && rise_cnt != '1) begin
        rise_cnt <= rise_cnt + 1'b1;
      end
      if (cs_n_o) begin
        if (hi_cnt < HI_W'(IDLE_CLKS)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
    end
  end

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst) cs_n_o |-> !sclk_o); // R10
  AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (rst) !cs_n_o |-> busy_o); // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o); // R7
  AST_VALID_ON_DESELECT: assert property (@(posedge clk) disable iff (rst) valid_o |-> $rose(cs_n_o)); // R7
  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (rst) (sk_q && !sclk_o) |-> (ev_cnt == ({1'b0, div_i} + 1'b1))); // R4
  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (rst) $rose(cs_n_o) |-> (rise_cnt == RC_W'(FRAME_CLKS))); // R3
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst) $fell(cs_n_o) |-> (hi_cnt >= HI_W'(IDLE_CLKS))); // R8

endmodule

bind adc_frame_reader adc_frame_reader_chk #(
  .DIV_W      (DIV_W),
  .FRAME_CLKS (FRAME_CLKS),
  .IDLE_CLKS  (IDLE_CLKS)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .div_i   (div_i),
  .cs_n_o  (cs_n_o),
  .sclk_o  (sclk_o),
  .valid_o (valid_o),
  .busy_o  (busy_o)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb_top;

  localparam int DATA_W = 16;
  localparam int LEAD   = 5;
  localparam int FRAME  = 24;
  localparam int DIV_W  = 8;
  localparam int IDLE   = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [DIV_W-1:0]  div = '0;
  logic              sdi;
  logic              cs_n, sclk, valid, busy, err;
  logic [DATA_W-1:0] result;

  adc_frame_reader #(
    .DATA_W(DATA_W), .LEAD_FALLS(LEAD), .FRAME_CLKS(FRAME), .DIV_W(DIV_W), .IDLE_CLKS(IDLE)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .div_i(div), .sdi_i(sdi),
    .cs_n_o(cs_n), .sclk_o(sclk), .result_o(result), .valid_o(valid),
    .busy_o(busy), .err_o(err)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // converter model: counts falling clock edges while selected
  logic [DATA_W-1:0] m_word = '0;
  logic m_mark = 1'b0, m_lead = 1'b0, m_tail = 1'b0;
  int fcnt = 0;

  always @(negedge cs_n) fcnt = 0;
  always @(negedge sclk) if (!cs_n) fcnt++;

  always_comb begin
    if (cs_n)                      sdi = 1'b1;
    else if (fcnt < LEAD)          sdi = m_lead;
    else if (fcnt == LEAD)         sdi = m_mark;
    else if (fcnt <= LEAD + DATA_W) sdi = m_word[LEAD + DATA_W - fcnt];
    else                           sdi = m_tail;
  end

  // frame measurements
  bit meas_on = 1'b0;
  int low_cyc = 0, hi_cyc = 0, rises = 0, desel_clk = 0;

  always @(negedge clk) begin
    if (meas_on && !cs_n) begin
      low_cyc++;
      if (sclk) hi_cyc++;
    end
    if (meas_on && cs_n && sclk) desel_clk++;
  end
  always @(posedge sclk) if (meas_on) rises++;

  task automatic run_frame(input logic [DATA_W-1:0] w, input bit mark, input bit lead,
                           input bit tail, input int d, input bit poke);
    string rq;
    int t, g, stray;
    while (busy) @(negedge clk);
    m_word = w; m_mark = mark; m_lead = lead; m_tail = tail;
    div = DIV_W'(d);
    low_cyc = 0; hi_cyc = 0; rises = 0; desel_clk = 0;
    meas_on = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cs_n == 1'b0 && busy == 1'b1, "R2", "select/busy after start", {cs_n, busy}, 2'b01);
    t = 0;
    while (!valid && t < 5000) begin
      @(negedge clk);
      t++;
      start = (poke && t == 30);
    end
    start = 1'b0;
    meas_on = 1'b0;
    rq = (lead || tail) ? "R9" : "R5";
    chk(valid == 1'b1, "R7", "valid seen", valid, 1);
    chk(result == w, rq, "result word", result, w);
    chk(err == mark, "R6", "marker error flag", err, mark);
    chk(cs_n == 1'b1, "R7", "select high with valid", cs_n, 1);
    chk(rises == FRAME, "R3", "rising edges per frame", rises, FRAME);
    chk(low_cyc == (2*FRAME+1)*(d+1), "R4", "select low cycles", low_cyc, (2*FRAME+1)*(d+1));
    chk(hi_cyc == FRAME*(d+1), "R4", "clock high cycles", hi_cyc, FRAME*(d+1));
    chk(desel_clk == 0, "R10", "clock high while deselected", desel_clk, 0);
    g = 1;
    @(negedge clk);
    chk(valid == 1'b0, "R7", "valid one cycle", valid, 0);
    chk(result == w && err == mark, "R7", "result held", result, w);
    while (busy && g < 1000) begin
      g++;
      @(negedge clk);
    end
    chk(g == IDLE, "R8", "busy cycles after deselect", g, IDLE);
    if (poke) begin
      stray = 0;
      for (int k = 0; k < 3*IDLE; k++) begin
        if (!cs_n || busy) stray++;
        @(negedge clk);
      end
      chk(stray == 0, "R2", "start during frame ignored", stray, 0);
    end
  endtask

  logic [DATA_W-1:0] pats [6] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'hA5C3, 16'h5A3C};

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "reset select/clock", {cs_n, sclk}, 2'b10);
    chk(busy == 1'b0 && valid == 1'b0 && err == 1'b0, "R1", "reset flags", {busy, valid, err}, 0);
    chk(result == '0, "R1", "reset result", result, 0);

    // divider sweep over fixed patterns, junk alternated in dead/trailing pulses
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < 6; i++) begin
        run_frame(pats[i], 1'b0, i[0], i[1], d, 1'b0);
      end
    end
    // walking one, all junk high
    for (int b = 0; b < DATA_W; b++) begin
      run_frame(DATA_W'(1) << b, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    end
    // walking zero at a slower clock
    for (int b = 0; b < DATA_W; b += 5) begin
      run_frame(~(DATA_W'(1) << b), 1'b0, 1'b0, 1'b1, 1, 1'b0);
    end
    // corrupted marker, then recovery
    run_frame(16'h1234, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    run_frame(16'hFEDC, 1'b1, 1'b1, 1'b0, 2, 1'b0);
    run_frame(16'h0F0F, 1'b0, 1'b1, 1'b1, 2, 1'b0);
    // start request inside a frame
    run_frame(16'hC001, 1'b0, 1'b0, 1'b0, 0, 1'b1);

    summary();
  end

endmodule